// File: doc/BRIEF.md
# Token-Started Loop Accumulator Filter

This block is one streaming filter stage placed between two FIFOs. It sits idle until a control token arrives. It then runs one firing. A firing clears an accumulator and a loop counter. It reads a fixed number of words from the upstream FIFO, one pop at a time, and adds each word into the accumulator. It then writes the finished total to the downstream FIFO in a single push. When the firing completes, the block returns a one-cycle acknowledge so that a scheduler can chain the next firing.

The firing is sequenced as four basic blocks: clear, read, add-and-branch, and write. Every FIFO access takes exactly one clock. The read block waits while the upstream FIFO is empty, and the write block waits while the downstream FIFO is full. The data width and the number of words per firing are parameters. The accumulator is sized so that a full firing of maximum-value words cannot wrap. A generate option selects whether the acknowledge is registered (default) or given in the same cycle as the push.

Top module: `acc_token_filter`

## Requirements
- R1: During reset and in the first cycle after it, `ack_o`, `rd_pop_o` and `wr_push_o` are all low, and the block is idle.
- R2: A token (`tok_i` high at a clock edge) starts a firing only when the block is idle. A token seen while a firing is in progress has no effect, so each completed firing produces exactly one push.
- R3: Each firing pops exactly COUNT words (default 8). `rd_pop_o` is never high while `rd_empty_i` is high, and the read block stays put without popping while the FIFO is empty.
- R4: Two pops never occur in consecutive cycles, because an add cycle always separates them. A pop and a push never occur in the same cycle.
- R5: The pushed `wr_data_o` equals the exact sum of the COUNT words popped in that firing, at a width of DATA_W + clog2(COUNT) bits. With DATA_W=16 and COUNT=8, eight words of 0xFFFF give 524280.
- R6: `wr_push_o` is never high while `wr_full_i` is high, and the write block holds its total until the FIFO has room.
- R7: With the registered acknowledge (default), `ack_o` is high for exactly one cycle, and that cycle immediately follows the push.
- R8: The accumulator and the loop counter are cleared at the start of every firing, so each total depends only on the words of its own firing.
- R9: With no stalls, a firing follows this timing. The token is seen at edge k. The first pop occurs in the cycle after edge k+1. Pops then follow every second cycle. The push occurs two cycles after the last pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_i | input | 1 | Control token that starts a firing when idle |
| ack_o | output | 1 | Firing-complete pulse |
| rd_data_i | input | DATA_W | Head word of the upstream FIFO |
| rd_empty_i | input | 1 | Upstream FIFO is empty |
| rd_pop_o | output | 1 | Pop the upstream FIFO this cycle |
| wr_data_o | output | DATA_W+clog2(COUNT) | Total to write downstream |
| wr_full_i | input | 1 | Downstream FIFO is full |
| wr_push_o | output | 1 | Push to the downstream FIFO this cycle |

## Verification
The bound checker watches several rules on every cycle:
- FIFO flow control, so that no pop happens on an empty FIFO and no push happens on a full one.
- The spacing of pops, with never two pops back to back and never a pop together with a push.
- A count of exactly COUNT pops before every push.
- A single-cycle acknowledge that follows each push.

Other behaviours can only be shown by the bench's scenarios, which drive a reference model fed from queues:
- The value of each total, including the all-maximum case that must not wrap.
- The clearing between firings.
- Tokens being ignored while a firing runs.
- The exact cycle-level timing under empty and full stalls.

// File: rtl/acc_pkg.sv
package acc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CLEAR = 3'd1,
      ST_READ  = 3'd2,
      ST_ADD   = 3'd3,
      ST_WRITE = 3'd4
   } acc_state_e;

   function automatic int sum_width(input int data_w, input int count);
      return data_w + $clog2(count);
   endfunction
endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
   import acc_pkg::*;
#(
   parameter bit ACK_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tok_i,
   input  logic rd_empty_i,
   input  logic wr_full_i,
   input  logic loop_last_i,
   output logic clr_o,
   output logic pop_o,
   output logic add_o,
   output logic push_o,
   output logic ack_o
);
   acc_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (tok_i) state_d = ST_CLEAR;
         ST_CLEAR: state_d = ST_READ;
         ST_READ:  if (!rd_empty_i) state_d = ST_ADD;
         ST_ADD:   state_d = loop_last_i ? ST_WRITE : ST_READ;
         ST_WRITE: if (!wr_full_i) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign clr_o  = (state_q == ST_CLEAR);
   assign pop_o  = (state_q == ST_READ)  && !rd_empty_i;
   assign add_o  = (state_q == ST_ADD);
   assign push_o = (state_q == ST_WRITE) && !wr_full_i;

   generate
      if (ACK_REGISTERED) begin : g_ack_reg
         logic ack_q;
         always_ff @(posedge clk) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= push_o;
         end
         assign ack_o = ack_q;
      end else begin : g_ack_comb
         assign ack_o = push_o;
      end
   endgenerate
endmodule

// File: rtl/acc_word_path.sv
module acc_word_path
   import acc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COUNT  = 8,
   localparam int SUM_W = sum_width(DATA_W, COUNT),
   localparam int IDX_W = $clog2(COUNT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              pop_i,
   input  logic              add_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [SUM_W-1:0]  sum_o,
   output logic              last_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COUNT - 1);

   logic [DATA_W-1:0] word_q;
   logic [SUM_W-1:0]  sum_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         sum_q  <= '0;
         idx_q  <= '0;
      end else begin
         if (pop_i) word_q <= rd_data_i;
         if (clr_i) begin
            sum_q <= '0;
            idx_q <= '0;
         end else if (add_i) begin
            sum_q <= sum_q + SUM_W'(word_q);
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign sum_o  = sum_q;
   assign last_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/acc_token_filter.sv
module acc_token_filter
   import acc_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int COUNT           = 8,
   parameter bit ACK_REGISTERED  = 1'b1,
   localparam int SUM_W          = sum_width(DATA_W, COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_i,
   output logic              ack_o,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_empty_i,
   output logic              rd_pop_o,
   output logic [SUM_W-1:0]  wr_data_o,
   input  logic              wr_full_i,
   output logic              wr_push_o
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("acc_token_filter: DATA_W must be at least 1");
      end
      if (COUNT < 1) begin : g_bad_count
         $error("acc_token_filter: COUNT must be at least 1");
      end
   endgenerate

   logic clr, add, last;

   acc_seq_ctrl #(.ACK_REGISTERED(ACK_REGISTERED)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .tok_i       (tok_i),
      .rd_empty_i  (rd_empty_i),
      .wr_full_i   (wr_full_i),
      .loop_last_i (last),
      .clr_o       (clr),
      .pop_o       (rd_pop_o),
      .add_o       (add),
      .push_o      (wr_push_o),
      .ack_o       (ack_o)
   );

   acc_word_path #(.DATA_W(DATA_W), .COUNT(COUNT)) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .pop_i     (rd_pop_o),
      .add_i     (add),
      .rd_data_i (rd_data_i),
      .sum_o     (wr_data_o),
      .last_o    (last)
   );
endmodule

// File: rtl/acc_token_filter_chk.sv
module acc_token_filter_chk #(
   parameter int DATA_W         = 16,
   parameter int COUNT          = 8,
   parameter bit ACK_REGISTERED = 1'b1,
   localparam int SUM_W         = DATA_W + $clog2(COUNT),
   localparam int CW            = $clog2(COUNT + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tok_i,
   input logic              ack_o,
   input logic [DATA_W-1:0] rd_data_i,
   input logic              rd_empty_i,
   input logic              rd_pop_o,
   input logic [SUM_W-1:0]  wr_data_o,
   input logic              wr_full_i,
   input logic              wr_push_o
);
   logic [CW-1:0] pops_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          pops_q <= '0;
      else if (wr_push_o)  pops_q <= '0;
      else if (rd_pop_o)   pops_q <= pops_q + 1'b1;
   end

   assert_pop_not_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop_o |-> !rd_empty_i);

   assert_pop_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_push_o |-> (pops_q == CW'(COUNT)));

   assert_pop_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_pop_o |=> !rd_pop_o);

   assert_no_pop_with_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_pop_o, wr_push_o}));

   assert_push_not_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_push_o |-> !wr_full_i);

   assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   generate
      if (ACK_REGISTERED) begin : g_ack_chk
         assert_ack_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wr_push_o |=> ack_o);
         assert_ack_only_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_push_o |=> !ack_o);
      end
   endgenerate
endmodule

bind acc_token_filter acc_token_filter_chk #(
   .DATA_W(DATA_W), .COUNT(COUNT), .ACK_REGISTERED(ACK_REGISTERED)
) u_chk (.*);

// File: tb/tb_acc_token_filter.sv
module tb_acc_token_filter;
   localparam int DATA_W = 16;
   localparam int COUNT  = 8;
   localparam int SUM_W  = DATA_W + $clog2(COUNT);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tok_i = 1'b0;
   logic              ack_o;
   logic [DATA_W-1:0] rd_data_i = '0;
   logic              rd_empty_i = 1'b1;
   logic              rd_pop_o;
   logic [SUM_W-1:0]  wr_data_o;
   logic              wr_full_i = 1'b0;
   logic              wr_push_o;

   acc_token_filter #(.DATA_W(DATA_W), .COUNT(COUNT)) dut (.*);

   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // reference model state
   int          ph = 0;      // 0 idle, 1 clear, 2 read, 3 add, 4 write
   longint      m_sum = 0;
   longint      m_word = 0;
   int          m_n = 0;
   bit          m_ack = 0;
   int          m_pushes = 0;
   int          d_pushes = 0;
   longint      last_push = 0;
   int          q[$];
   bit          tok = 0, rd_stall = 0, wr_stall = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step();
      bit e_pop, e_push, empty;
      @(negedge clk);
      empty      = (q.size() == 0) || rd_stall;
      rd_empty_i = empty;
      rd_data_i  = (q.size() != 0) ? DATA_W'(q[0]) : '0;
      wr_full_i  = wr_stall;
      tok_i      = tok;
      #1;
      e_pop  = (ph == 2) && !empty;
      e_push = (ph == 4) && !wr_stall;
      check(rd_pop_o == e_pop, "R3 R4 R9 pop", rd_pop_o, e_pop);
      check(wr_push_o == e_push, "R6 R9 push", wr_push_o, e_push);
      check(ack_o == m_ack, "R7 ack", ack_o, m_ack);
      if (e_push && wr_push_o)
         check(wr_data_o == SUM_W'(m_sum), "R5 R8 total", wr_data_o, m_sum);
      if (wr_push_o) begin
         d_pushes++;
         last_push = wr_data_o;
      end
      @(posedge clk);
      m_ack = e_push;
      case (ph)
         0: if (tok) ph = 1;
         1: begin m_sum = 0; m_n = 0; ph = 2; end
         2: if (e_pop) begin m_word = q.pop_front(); ph = 3; end
         3: begin m_sum += m_word; m_n++; ph = (m_n < COUNT) ? 2 : 4; end
         4: if (e_push) begin ph = 0; m_pushes++; end
         default: ph = 0;
      endcase
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!ack_o && !rd_pop_o && !wr_push_o, "R1 reset outputs", {ack_o, rd_pop_o, wr_push_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!ack_o && !rd_pop_o && !wr_push_o, "R1 after reset", {ack_o, rd_pop_o, wr_push_o}, 0);

      for (int s = 0; s < 5; s++) begin
         int p0 = m_pushes;
         int d0 = d_pushes;
         for (int c = 0; c < 600; c++) begin
            int w;
            case (s)
               0: w = $urandom % (1 << DATA_W);
               1: w = (1 << DATA_W) - 1;
               2: w = $urandom % (1 << DATA_W);
               3: w = c;
               default: w = $urandom % 2;
            endcase
            if (q.size() < 4 && (s != 3 || (c % 5) == 0)) q.push_back(w);
            case (s)
               0: begin tok = 1; rd_stall = 0; wr_stall = 0; end       // token held high: R2
               1: begin tok = ((c % 40) == 0); rd_stall = 0; wr_stall = 0; end
               2: begin tok = ((c % 7) == 0); rd_stall = ($urandom % 3) == 0; wr_stall = ($urandom % 2) == 0; end
               3: begin tok = 1; rd_stall = 0; wr_stall = 0; end
               default: begin tok = ((c % 11) == 0); rd_stall = 0; wr_stall = ((c / 20) % 2) == 1; end
            endcase
            step();
         end
         tok = 0; rd_stall = 0; wr_stall = 0;
         for (int c = 0; c < 60; c++) begin
            if (q.size() < 4) q.push_back(1);
            step();
         end
         check(m_pushes > p0, "R2 firings occurred", m_pushes - p0, 1);
         check((d_pushes - d0) == (m_pushes - p0), "R2 one push per firing", d_pushes - d0, m_pushes - p0);
         if (s == 1)
            check(last_push == longint'(COUNT) * ((1 << DATA_W) - 1), "R5 max total", last_push,
                  longint'(COUNT) * ((1 << DATA_W) - 1));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule